// File: doc/BRIEF.md
# USB Device Speed Negotiation Controller

This block is the link-state controller that lets a USB device settle on full-speed or high-speed signalling. It watches decoded line-state indicators (single-ended zero, J, K), a strobe that marks bus activity and a timebase tick. From these it drives a speed select to the transceiver, a request to drive the device chirp, a one-cycle bus-reset pulse and a suspend indication. It does no analog work, no line coding and no packet decoding.

After power-up or reset the device sits at full speed. When it sees a single-ended zero that lasts the reset window, it pulses the bus-reset output and drives the device chirp. It then counts alternating host K/J chirp pairs and moves to high speed once it has seen enough of them. If the host never answers, it stays at full speed. In high speed it counts idle time, and any bus activity restarts that count. Once the idle limit is reached it falls back to full-speed signalling and samples the line. A single-ended zero that holds through the reset window is taken as a new reset and starts a fresh chirp. Anything else is taken as suspend.

All durations are parameters counted in timebase ticks. A system can therefore use real microsecond ticks, and a bench can use very short windows.

Top module: `usb_speed_neg`

## Requirements
- R1: After reset, hs_sel, chirp_drv, bus_reset and suspend_flag are all 0, and the block is in the full-speed state.
- R2: In the full-speed or suspend state, line_se0 held for RESET_TICKS ticks causes a detected reset: bus_reset and chirp_drv rise on the same clock edge. A shorter single-ended zero has no effect.
- R3: chirp_drv stays high until CHIRP_TICKS ticks have elapsed in the chirp state, then falls as the block starts waiting for the host.
- R4: While waiting, MIN_PAIRS host chirp pairs, each a K (line_k=1, line_j=0) followed by a J (line_j=1, line_k=0), make hs_sel rise.
- R5: If fewer than MIN_PAIRS pairs arrive within HOST_WAIT_TICKS ticks, the block returns to full speed. Host chirps after that have no effect on hs_sel.
- R6: In high speed, a bus_active strobe restarts the idle count from zero. IDLE_TICKS ticks without activity drop hs_sel to 0.
- R7: After the idle drop, line_se0 held through RESET_TICKS ticks counts as a new reset: bus_reset pulses and chirp_drv rises.
- R8: If the line is not single-ended zero throughout that window, suspend_flag rises. A bus_active strobe or a K on the line clears it.
- R9: All timers advance only on cycles where tick is 1.
- R10: bus_reset is high for exactly one clock cycle per detected reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase strobe; one timer step per high cycle |
| line_se0 | input | 1 | Line is single-ended zero |
| line_j | input | 1 | Line is in J state (host chirp J while waiting) |
| line_k | input | 1 | Line is in K state (host chirp K while waiting) |
| bus_active | input | 1 | Strobe marking bus activity |
| hs_sel | output | 1 | 1 selects high-speed signalling, 0 full speed |
| chirp_drv | output | 1 | Request to drive the device chirp K |
| bus_reset | output | 1 | One-cycle pulse per detected bus reset |
| suspend_flag | output | 1 | Suspend detected after high-speed idle |

## Verification
The bench targets four corner cases:
- Single-ended zero one tick short of the reset window. A design that gets this wrong chirps early.
- A host that stays silent. A wrong design either hangs in the wait or accepts late chirps as high speed.
- Bus activity one tick before the idle limit. A design that never restarts the count drops to full speed while traffic is still flowing.
- The post-idle probe, where a design that confuses reset with suspend either reports suspend during a host reset or starts a chirp into a suspended bus.

The bench also holds tick low for a long stretch of single-ended zero. A design whose timers count clock cycles would chirp during that stretch. Finally, it counts bus-reset pulses to catch widths longer than one cycle.

// File: rtl/usb_spd_pkg.sv
package usb_spd_pkg;

  typedef enum logic [2:0] {
    LS_FS    = 3'd0,
    LS_SUSP  = 3'd1,
    LS_CHIRP = 3'd2,
    LS_WAIT  = 3'd3,
    LS_HS    = 3'd4,
    LS_PROBE = 3'd5
  } link_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/usb_tick_timer.sv
module usb_tick_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] cnt
);
  // saturating tick counter; clear has priority
  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (tick && (cnt != '1))
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/usb_chirp_pairs.sv
module usb_chirp_pairs #(
  parameter int unsigned PW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          line_j,
  input  logic          line_k,
  output logic [PW-1:0] pairs
);
  logic want_k;

  // a pair is a clean K followed by a clean J; levels may last several cycles
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      want_k <= 1'b1;
      pairs  <= '0;
    end else if (want_k && line_k && !line_j) begin
      want_k <= 1'b0;
    end else if (!want_k && line_j && !line_k) begin
      want_k <= 1'b1;
      if (pairs != '1) pairs <= pairs + 1'b1;
    end
  end
endmodule

// File: rtl/usb_speed_neg.sv
module usb_speed_neg
  import usb_spd_pkg::*;
#(
  parameter int unsigned RESET_TICKS     = 250,
  parameter int unsigned CHIRP_TICKS     = 2000,
  parameter int unsigned HOST_WAIT_TICKS = 6000,
  parameter int unsigned IDLE_TICKS      = 3000,
  parameter int unsigned MIN_PAIRS       = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic line_se0,
  input  logic line_j,
  input  logic line_k,
  input  logic bus_active,
  output logic hs_sel,
  output logic chirp_drv,
  output logic bus_reset,
  output logic suspend_flag
);
  localparam int unsigned MAXT = max2(max2(RESET_TICKS, CHIRP_TICKS),
                                      max2(HOST_WAIT_TICKS, IDLE_TICKS));
  localparam int unsigned CW   = $clog2(MAXT + 1);
  localparam int unsigned PW   = $clog2(MIN_PAIRS + 1);
  localparam int unsigned NTMR = 2;  // 0: phase timer, 1: se0 timer

  link_state_e state_q, state_d;
  logic        rst_evt;
  logic [CW-1:0] tmr_cnt [NTMR];
  logic [NTMR-1:0] tmr_clr;
  logic [CW-1:0] ph_cnt, se0_cnt;
  logic [PW-1:0] pair_cnt;
  logic          se0_hit, leave;

  assign ph_cnt  = tmr_cnt[0];
  assign se0_cnt = tmr_cnt[1];
  assign leave   = (state_d != state_q);
  assign se0_hit = (se0_cnt >= CW'(RESET_TICKS));

  // phase timer restarts on every state change and on activity in high speed
  assign tmr_clr[0] = leave || ((state_q == LS_HS) && bus_active);
  // se0 timer only measures a continuous single-ended zero in sampling states
  assign tmr_clr[1] = !line_se0 || leave || (state_q == LS_CHIRP) ||
                      (state_q == LS_WAIT) || (state_q == LS_HS);

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    usb_tick_timer #(.W(CW)) u_tmr (
      .clk (clk),
      .rst (rst),
      .clr (tmr_clr[g]),
      .tick(tick),
      .cnt (tmr_cnt[g])
    );
  end

  usb_chirp_pairs #(.PW(PW)) u_pairs (
    .clk   (clk),
    .rst   (rst),
    .clr   (state_q != LS_WAIT),
    .line_j(line_j),
    .line_k(line_k),
    .pairs (pair_cnt)
  );

  always_comb begin
    state_d = state_q;
    rst_evt = 1'b0;
    unique case (state_q)
      LS_FS: begin
        if (se0_hit) begin
          rst_evt = 1'b1;
          state_d = LS_CHIRP;
        end
      end
      LS_SUSP: begin
        if (se0_hit) begin
          rst_evt = 1'b1;
          state_d = LS_CHIRP;
        end else if (bus_active || line_k) begin
          state_d = LS_FS;
        end
      end
      LS_CHIRP: begin
        if (ph_cnt >= CW'(CHIRP_TICKS)) state_d = LS_WAIT;
      end
      LS_WAIT: begin
        if (pair_cnt >= PW'(MIN_PAIRS))              state_d = LS_HS;
        else if (ph_cnt >= CW'(HOST_WAIT_TICKS))     state_d = LS_FS;
      end
      LS_HS: begin
        if (!bus_active && (ph_cnt >= CW'(IDLE_TICKS))) state_d = LS_PROBE;
      end
      LS_PROBE: begin
        if (se0_hit) begin
          rst_evt = 1'b1;
          state_d = LS_CHIRP;
        end else if (ph_cnt >= CW'(RESET_TICKS)) begin
          state_d = LS_SUSP;
        end
      end
      default: state_d = LS_FS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= LS_FS;
      hs_sel       <= 1'b0;
      chirp_drv    <= 1'b0;
      suspend_flag <= 1'b0;
      bus_reset    <= 1'b0;
    end else begin
      state_q      <= state_d;
      hs_sel       <= (state_d == LS_HS);
      chirp_drv    <= (state_d == LS_CHIRP);
      suspend_flag <= (state_d == LS_SUSP);
      bus_reset    <= rst_evt;
    end
  end
endmodule

// File: rtl/usb_speed_neg_chk.sv
module usb_speed_neg_chk #(
  parameter int unsigned CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          bus_active,
  input logic          hs_sel,
  input logic          chirp_drv,
  input logic          bus_reset,
  input logic          suspend_flag,
  input logic [CW-1:0] ph_cnt
);
  p_out_excl_r1: assert property (@(posedge clk) disable iff (rst)
    !(hs_sel && (chirp_drv || suspend_flag)));

  p_reset_chirp_r2: assert property (@(posedge clk) disable iff (rst)
    bus_reset |-> chirp_drv);

  p_hs_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (hs_sel && bus_active) |=> hs_sel);

  p_chirp_start_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(chirp_drv) |-> bus_reset);

  p_susp_exit_r8: assert property (@(posedge clk) disable iff (rst)
    (suspend_flag && bus_active) |=> !suspend_flag);

  p_no_tick_r9: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ((ph_cnt == $past(ph_cnt)) || (ph_cnt == '0)));

  p_pulse_one_r10: assert property (@(posedge clk) disable iff (rst)
    bus_reset |=> !bus_reset);
endmodule

bind usb_speed_neg usb_speed_neg_chk #(.CW(CW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick        (tick),
  .bus_active  (bus_active),
  .hs_sel      (hs_sel),
  .chirp_drv   (chirp_drv),
  .bus_reset   (bus_reset),
  .suspend_flag(suspend_flag),
  .ph_cnt      (ph_cnt)
);

// File: tb/test_usb_speed_neg.sv
`timescale 1ns/1ps
module test_usb_speed_neg;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1, line_se0 = 1'b0, line_j = 1'b0, line_k = 1'b0, bus_active = 1'b0;
  logic hs_sel, chirp_drv, bus_reset, suspend_flag;

  int checks = 0, errors = 0, pulses = 0, width_err = 0;
  logic prev_pulse = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  usb_speed_neg #(
    .RESET_TICKS(4), .CHIRP_TICKS(5), .HOST_WAIT_TICKS(20),
    .IDLE_TICKS(8), .MIN_PAIRS(3)
  ) i_usb_speed_neg (
    .clk(clk), .rst(rst), .tick(tick), .line_se0(line_se0), .line_j(line_j),
    .line_k(line_k), .bus_active(bus_active), .hs_sel(hs_sel),
    .chirp_drv(chirp_drv), .bus_reset(bus_reset), .suspend_flag(suspend_flag)
  );

  // bus-reset pulse monitor (R10)
  always @(negedge clk) begin
    if (rst) prev_pulse = 1'b0;
    else begin
      if (bus_reset) pulses++;
      if (bus_reset && prev_pulse) width_err++;
      prev_pulse = bus_reset;
    end
  end

  // fields: [18:15] req, [14] se0, [13] j, [12] k, [11] act, [10:3] cycles, [2] hs, [1] chirp, [0] susp
  localparam int NV = 29;
  localparam logic [18:0] VEC [NV] = '{
    {4'd1,  4'b0000, 8'd3,  3'b000},  // R1 idle after reset
    {4'd2,  4'b1000, 8'd3,  3'b000},  // R2 se0 too short so far
    {4'd2,  4'b1000, 8'd2,  3'b010},  // R2 reset detected, chirp
    {4'd3,  4'b0000, 8'd5,  3'b010},  // R3 chirp still driven
    {4'd3,  4'b0000, 8'd1,  3'b000},  // R3 chirp ends
    {4'd4,  4'b0010, 8'd2,  3'b000},  // R4 host K
    {4'd4,  4'b0100, 8'd2,  3'b000},  // R4 host J
    {4'd4,  4'b0010, 8'd2,  3'b000},
    {4'd4,  4'b0100, 8'd2,  3'b000},
    {4'd4,  4'b0010, 8'd2,  3'b000},
    {4'd4,  4'b0100, 8'd2,  3'b100},  // R4 third pair -> high speed
    {4'd6,  4'b0001, 8'd20, 3'b100},  // R6 activity keeps high speed
    {4'd6,  4'b0000, 8'd8,  3'b100},  // R6 idle one short
    {4'd6,  4'b0000, 8'd1,  3'b000},  // R6 idle limit -> full speed
    {4'd8,  4'b0100, 8'd4,  3'b000},  // R8 probing, line J
    {4'd8,  4'b0100, 8'd1,  3'b001},  // R8 suspend
    {4'd8,  4'b0001, 8'd1,  3'b000},  // R8 activity leaves suspend
    {4'd2,  4'b1000, 8'd3,  3'b000},  // R2 short se0
    {4'd2,  4'b0100, 8'd2,  3'b000},  // R2 short se0 ignored
    {4'd2,  4'b1000, 8'd5,  3'b010},  // R2 second reset
    {4'd3,  4'b0000, 8'd6,  3'b000},  // R3 waiting for host
    {4'd5,  4'b0000, 8'd21, 3'b000},  // R5 host silent, timeout
    {4'd5,  4'b0010, 8'd2,  3'b000},  // R5 late chirps ignored
    {4'd5,  4'b0100, 8'd2,  3'b000},
    {4'd5,  4'b0010, 8'd2,  3'b000},
    {4'd5,  4'b0100, 8'd2,  3'b000},
    {4'd5,  4'b0010, 8'd2,  3'b000},
    {4'd5,  4'b0100, 8'd2,  3'b000},
    {4'd5,  4'b0000, 8'd3,  3'b000}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input int req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %0b expected %0b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic negotiate();
    line_se0 = 1'b1; step(5);
    chk(2, "chirp after reset (R2)", chirp_drv, 1'b1);
    line_se0 = 1'b0; step(6);
    chk(3, "chirp end (R3)", chirp_drv, 1'b0);
    repeat (3) begin
      line_k = 1'b1; step(2);
      line_k = 1'b0; line_j = 1'b1; step(2);
      line_j = 1'b0;
    end
    chk(4, "high speed after pairs (R4)", hs_sel, 1'b1);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(4);
    rst = 1'b0;
    // R1 reset state
    chk(1, "hs_sel reset (R1)", hs_sel, 1'b0);
    chk(1, "chirp_drv reset (R1)", chirp_drv, 1'b0);
    chk(1, "bus_reset reset (R1)", bus_reset, 1'b0);
    chk(1, "suspend reset (R1)", suspend_flag, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [18:0] v;
      v = VEC[i];
      line_se0 = v[14]; line_j = v[13]; line_k = v[12]; bus_active = v[11];
      step(int'(v[10:3]));
      chk(int'(v[18:15]), $sformatf("vector %0d hs_sel", i), hs_sel, v[2]);
      chk(int'(v[18:15]), $sformatf("vector %0d chirp_drv", i), chirp_drv, v[1]);
      chk(int'(v[18:15]), $sformatf("vector %0d suspend", i), suspend_flag, v[0]);
    end
    line_se0 = 1'b0; line_j = 1'b0; line_k = 1'b0; bus_active = 1'b0;

    // R9: no tick, no timer progress
    tick = 1'b0; line_se0 = 1'b1; step(30);
    chk(9, "no chirp without ticks (R9)", chirp_drv, 1'b0);
    tick = 1'b1; step(4);
    chk(9, "one tick short (R9)", chirp_drv, 1'b0);
    step(1);
    chk(9, "chirp after ticks (R9)", chirp_drv, 1'b1);
    line_se0 = 1'b0; step(30);

    // R6 and R7: periodic activity, then idle with se0 -> new reset
    negotiate();
    repeat (7) begin
      bus_active = 1'b1; step(1);
      bus_active = 1'b0; step(5);
    end
    chk(6, "periodic activity holds high speed (R6)", hs_sel, 1'b1);
    bus_active = 1'b1; step(1);
    bus_active = 1'b0; line_se0 = 1'b1; step(8);
    chk(6, "high speed before idle limit (R6)", hs_sel, 1'b1);
    step(1);
    chk(6, "full speed at idle limit (R6)", hs_sel, 1'b0);
    step(4);
    chk(7, "no chirp before window (R7)", chirp_drv, 1'b0);
    step(1);
    chk(7, "chirp after probe se0 (R7)", chirp_drv, 1'b1);
    chk(7, "bus_reset pulse on probe (R7)", bus_reset, 1'b1);
    chk(7, "no suspend on reset (R7)", suspend_flag, 1'b0);
    step(1);
    chk(10, "bus_reset falls (R10)", bus_reset, 1'b0);
    line_se0 = 1'b0; step(30);

    // R8: suspend then K exit
    negotiate();
    step(9);
    chk(8, "idle drop (R8)", hs_sel, 1'b0);
    line_j = 1'b1; step(5);
    chk(8, "suspend flagged (R8)", suspend_flag, 1'b1);
    line_j = 1'b0; line_k = 1'b1; step(1);
    chk(8, "K leaves suspend (R8)", suspend_flag, 1'b0);
    line_k = 1'b0; step(3);

    chk(10, "pulse count is 6 (R10)", pulses == 6, 1'b1);
    chk(10, "pulse width one cycle (R10)", width_err == 0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule